// File: doc/BRIEF.md
# Prioritised Interrupt Claim Controller

This block gathers a configurable number of level-sensitive interrupt lines (identifiers 1 to `NUM_SRC`, default 31) for a single processor context. It raises one interrupt request towards the core. Software controls it through 32-bit memory-mapped words on a simple bus. The bus always accepts a request, and read data returns on the following clock cycle.

Each source has three pieces of state: a 3-bit priority, an enable bit and a latched pending bit. A context threshold filters out low-priority sources. A read of the claim word returns the winning source and takes it out of the pending set, both in the same cycle. The handler later writes that identifier back to the same word to end the service. A claimed source is not latched again until that write arrives, so a line that is still high cannot interrupt its own handler.

Top module: `intc_claim_top`

## Requirements
- R1: A source line that is high sets its pending bit whatever its enable bit holds. Pending bits stay set until claimed. The pending word (byte address 0x1000) is read-only, and writes to it have no effect.
- R2: A read of the claim word (byte address 0x200004) returns the identifier of the qualifying source with the largest priority. When priorities are equal, the smallest identifier wins.
- R3: A source qualifies only if it is pending, enabled, and has a priority strictly greater than the threshold. A priority of 0 never qualifies.
- R4: A claim read that finds no qualifying source returns 0 and changes no state.
- R5: A claim read clears the pending bit of the identifier it returns, in the same cycle.
- R6: A claimed source is not latched as pending again until its identifier is written to the claim word. After that write, a line that is still high is latched again.
- R7: `irqOut` is high exactly when at least one source qualifies under R3.
- R8: Identifier 0 has no state. Its priority word and its bit 0 in the pending and enable words always read 0, and writes to them are ignored.
- R9: Register layout is as follows. The priority of source n is at byte 4·n. The enable word is at 0x2000. The threshold is at 0x200000. Source n sits at bit n%32 of word n/32 in the pending and enable words. Priority and threshold keep bits [2:0] only, and the upper bits read 0.
- R10: `busReady` is always high. `busRvalid` pulses for one cycle, in the cycle after each accepted read and only then, with `busRdata` valid in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busReq | input | 1 | Bus request |
| busWe | input | 1 | 1 = write, 0 = read |
| busAddr | input | 22 | Byte address |
| busWdata | input | 32 | Write data |
| busReady | output | 1 | Request accepted (always 1) |
| busRdata | output | 32 | Read data, one cycle after the request |
| busRvalid | output | 1 | Read data valid |
| srcIn | input | NUM_SRC | Level interrupt lines, bit n is source n |
| irqOut | output | 1 | Interrupt request to the core |

## Verification
The bench runs 24 configurations: three priority patterns, each combined with every threshold value from 0 to 7. Half of the configurations raise every line and half raise only alternate lines, and the enable masks vary. In each configuration the claim word is read until it returns 0, and every returned identifier is compared with a model. Because the priority patterns repeat values, the tie rule is exercised. Because they include priority 0, exclusion by the threshold is exercised. The pending word is read after the claims, which separates clearing on claim from re-latching of lines that are still high. It is read again after the completions, which shows that completion re-arms those lines. Sweeps over all priority words with out-of-range data cover the masking, the register layout and identifier 0.

// File: rtl/intc_claim_pkg.sv
package intc_claim_pkg;
  localparam int ADDR_W = 22;

  typedef enum logic [2:0] {
    RD_ZERO, RD_PRIO, RD_PEND, RD_EN, RD_THR, RD_CLAIM
  } rdKind_e;

  typedef struct packed {
    logic    rdEn;
    logic    prioWr;
    logic    enWr;
    logic    thrWr;
    logic    complWr;
    logic    claimRd;
    rdKind_e rdKind;
    logic [9:0] idx;
  } busStrobe_t;
endpackage

// File: rtl/intc_claim_ctrl.sv
module intc_claim_ctrl
  import intc_claim_pkg::*;
(
  input  logic              busReq,
  input  logic              busWe,
  input  logic [ADDR_W-1:0] busAddr,
  output busStrobe_t        strb
);
  rdKind_e kind;
  logic wr, rd;

  always_comb begin
    kind = RD_ZERO;
    if (busAddr[1:0] == 2'b00) begin
      if (busAddr[21]) begin
        if (busAddr[20:0] == 21'h0)      kind = RD_THR;
        else if (busAddr[20:0] == 21'h4) kind = RD_CLAIM;
      end else begin
        case (busAddr[20:12])
          9'd0:    kind = RD_PRIO;
          9'd1:    kind = RD_PEND;
          9'd2:    kind = RD_EN;
          default: kind = RD_ZERO;
        endcase
      end
    end
  end

  assign wr = busReq && busWe;
  assign rd = busReq && !busWe;

  always_comb begin
    strb.rdEn    = rd;
    strb.prioWr  = wr && (kind == RD_PRIO);
    strb.enWr    = wr && (kind == RD_EN);
    strb.thrWr   = wr && (kind == RD_THR);
    strb.complWr = wr && (kind == RD_CLAIM);
    strb.claimRd = rd && (kind == RD_CLAIM);
    strb.rdKind  = kind;
    strb.idx     = busAddr[11:2];
  end
endmodule

// File: rtl/intc_claim_dp.sv
module intc_claim_dp
  import intc_claim_pkg::*;
#(
  parameter int NUM_SRC = 31,
  parameter int PRIO_W  = 3
) (
  input  logic               clk,
  input  logic               rstN,
  input  busStrobe_t         strb,
  input  logic [31:0]        busWdata,
  input  logic [NUM_SRC:1]   srcIn,
  output logic [31:0]        busRdata,
  output logic               busRvalid,
  output logic               irqOut,
  output logic [NUM_SRC:0]   pendVec,
  output logic [NUM_SRC:0]   servVec
);
  localparam int SRC_CNT   = NUM_SRC + 1;
  localparam int ID_W      = $clog2(SRC_CNT);
  localparam int NUM_WORDS = (SRC_CNT + 31) / 32;
  localparam int FLAT_W    = NUM_WORDS * 32;

  logic [NUM_SRC:0]    enVec;
  logic [PRIO_W-1:0]   prioVec [SRC_CNT];
  logic [PRIO_W-1:0]   thrQ;
  logic [ID_W-1:0]     bestId;
  logic [PRIO_W-1:0]   bestPrio;
  logic [FLAT_W-1:0]   pendFlat, enFlat;
  logic [31:0]         rdNext;

  assign pendVec[0] = 1'b0;
  assign servVec[0] = 1'b0;
  assign enVec[0]   = 1'b0;
  assign prioVec[0] = '0;

  for (genvar i = 1; i < SRC_CNT; i++) begin : g_src
    logic [PRIO_W-1:0] prioR;
    logic pendR, servR, enR;
    logic claimHit, complHit;
    assign claimHit = strb.claimRd && (bestId == ID_W'(i));
    assign complHit = strb.complWr && (busWdata == 32'(i));
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        prioR <= '0;
        pendR <= 1'b0;
        servR <= 1'b0;
        enR   <= 1'b0;
      end else begin
        if (strb.prioWr && strb.idx == 10'(i)) prioR <= busWdata[PRIO_W-1:0];
        if (strb.enWr && strb.idx == 10'(i / 32)) enR <= busWdata[i % 32];
        if (claimHit)      servR <= 1'b1;
        else if (complHit) servR <= 1'b0;
        if (claimHit)                 pendR <= 1'b0;
        else if (srcIn[i] && !servR)  pendR <= 1'b1;
      end
    end
    assign prioVec[i] = prioR;
    assign pendVec[i] = pendR;
    assign servVec[i] = servR;
    assign enVec[i]   = enR;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) thrQ <= '0;
    else if (strb.thrWr) thrQ <= busWdata[PRIO_W-1:0];
  end

  // Ascending scan with strict compare: lowest ID wins ties.
  always_comb begin
    bestId   = '0;
    bestPrio = '0;
    for (int i = 1; i < SRC_CNT; i++) begin
      if (pendVec[i] && enVec[i] && prioVec[i] > thrQ && prioVec[i] > bestPrio) begin
        bestId   = ID_W'(i);
        bestPrio = prioVec[i];
      end
    end
  end

  assign irqOut   = (bestId != '0);
  assign pendFlat = FLAT_W'(pendVec);
  assign enFlat   = FLAT_W'(enVec);

  always_comb begin
    rdNext = '0;
    case (strb.rdKind)
      RD_PRIO:
        for (int i = 0; i < SRC_CNT; i++)
          if (strb.idx == 10'(i)) rdNext = 32'(prioVec[i]);
      RD_PEND:
        for (int w = 0; w < NUM_WORDS; w++)
          if (strb.idx == 10'(w)) rdNext = pendFlat[w*32 +: 32];
      RD_EN:
        for (int w = 0; w < NUM_WORDS; w++)
          if (strb.idx == 10'(w)) rdNext = enFlat[w*32 +: 32];
      RD_THR:   rdNext = 32'(thrQ);
      RD_CLAIM: rdNext = 32'(bestId);
      default:  rdNext = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busRdata  <= '0;
      busRvalid <= 1'b0;
    end else begin
      busRvalid <= strb.rdEn;
      if (strb.rdEn) busRdata <= rdNext;
    end
  end
endmodule

// File: rtl/intc_claim_top.sv
module intc_claim_top
  import intc_claim_pkg::*;
#(
  parameter int NUM_SRC = 31,
  parameter int PRIO_W  = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busReq,
  input  logic              busWe,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [31:0]       busWdata,
  output logic              busReady,
  output logic [31:0]       busRdata,
  output logic              busRvalid,
  input  logic [NUM_SRC:1]  srcIn,
  output logic              irqOut
);
  busStrobe_t strb;
  logic [NUM_SRC:0] pendVec, servVec;

  assign busReady = 1'b1;

  intc_claim_ctrl ctrl_i (
    .busReq (busReq),
    .busWe  (busWe),
    .busAddr(busAddr),
    .strb   (strb)
  );

  intc_claim_dp #(.NUM_SRC(NUM_SRC), .PRIO_W(PRIO_W)) dp_i (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .busWdata (busWdata),
    .srcIn    (srcIn),
    .busRdata (busRdata),
    .busRvalid(busRvalid),
    .irqOut   (irqOut),
    .pendVec  (pendVec),
    .servVec  (servVec)
  );
endmodule

// File: rtl/intc_claim_chk.sv
module intc_claim_chk #(
  parameter int NUM_SRC = 31
) (
  input logic             clk,
  input logic             rstN,
  input logic             busReq,
  input logic             busWe,
  input logic [21:0]      busAddr,
  input logic [31:0]      busRdata,
  input logic             busRvalid,
  input logic             irqOut,
  input logic [NUM_SRC:0] pendVec,
  input logic [NUM_SRC:0] servVec
);
  localparam int ID_W = $clog2(NUM_SRC + 1);
  logic isRead, isClaim;
  assign isRead  = busReq && !busWe;
  assign isClaim = isRead && (busAddr == 22'h200004);

  AST_RVALID_AFTER_READ: assert property (@(posedge clk) disable iff (!rstN)
    isRead |=> busRvalid);                                          // R10
  AST_RVALID_ONLY_READ: assert property (@(posedge clk) disable iff (!rstN)
    !isRead |=> !busRvalid);                                        // R10
  AST_EMPTY_CLAIM_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (isClaim && !irqOut) |=> (busRdata == 32'd0));                  // R4
  AST_CLAIM_HAS_ID: assert property (@(posedge clk) disable iff (!rstN)
    (isClaim && irqOut) |=> (busRdata != 32'd0));                   // R2
  AST_CLAIM_CLEARS_PEND: assert property (@(posedge clk) disable iff (!rstN)
    (isClaim && irqOut) |=> !pendVec[busRdata[ID_W-1:0]]);          // R5
  AST_SERV_NOT_PEND: assert property (@(posedge clk) disable iff (!rstN)
    (pendVec & servVec) == '0);                                     // R6
endmodule

bind intc_claim_top intc_claim_chk #(.NUM_SRC(NUM_SRC)) chk_i (
  .clk      (clk),
  .rstN     (rstN),
  .busReq   (busReq),
  .busWe    (busWe),
  .busAddr  (busAddr),
  .busRdata (busRdata),
  .busRvalid(busRvalid),
  .irqOut   (irqOut),
  .pendVec  (pendVec),
  .servVec  (servVec)
);

// File: tb/intc_claim_top_tb_top.sv
module intc_claim_top_tb_top;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic        rstN = 1'b0;
  logic        busReq = 1'b0, busWe = 1'b0;
  logic [21:0] busAddr = '0;
  logic [31:0] busWdata = '0;
  logic [31:1] srcVec = '0;
  logic        busReady, busRvalid, irqOut;
  logic [31:0] busRdata;

  intc_claim_top dut_i (
    .clk(clk), .rstN(rstN), .busReq(busReq), .busWe(busWe), .busAddr(busAddr),
    .busWdata(busWdata), .busReady(busReady), .busRdata(busRdata),
    .busRvalid(busRvalid), .srcIn(srcVec), .irqOut(irqOut)
  );

  int checks = 0, errors = 0;
  bit done = 1'b0;
  bit mPend[32], mServ[32], mEn[32];
  int mPrio[32];
  int mThr = 0;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic busWrite(input logic [21:0] a, input logic [31:0] d);
    @(negedge clk); busReq = 1'b1; busWe = 1'b1; busAddr = a; busWdata = d;
    @(negedge clk); busReq = 1'b0; busWe = 1'b0;
  endtask

  task automatic busRead(input logic [21:0] a, output logic [31:0] d);
    @(negedge clk); busReq = 1'b1; busWe = 1'b0; busAddr = a;
    @(negedge clk); busReq = 1'b0; d = busRdata;
  endtask

  function automatic int expBest();
    int best = 0, bp = 0;
    for (int i = 1; i < 32; i++)
      if (mPend[i] && mEn[i] && mPrio[i] > mThr && mPrio[i] > bp) begin
        best = i; bp = mPrio[i];
      end
    return best;
  endfunction

  function automatic logic [31:0] pendWord();
    logic [31:0] w = '0;
    for (int i = 1; i < 32; i++) w[i] = mPend[i];
    return w;
  endfunction

  task automatic modelSettle();
    for (int i = 1; i < 32; i++) if (srcVec[i] && !mServ[i]) mPend[i] = 1'b1;
  endtask

  initial begin
    logic [31:0] d;
    int e;
    for (int i = 0; i < 32; i++) begin mPend[i] = 0; mServ[i] = 0; mEn[i] = 0; mPrio[i] = 0; end
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // Reset state
    @(negedge clk);
    chk("R7 reset irq", 32'(irqOut), 32'd0);
    chk("R10 ready", 32'(busReady), 32'd1);
    busRead(22'h200004, d); chk("R4 reset claim", d, 32'd0);
    chk("R10 rvalid after read", 32'(busRvalid), 32'd1);
    @(negedge clk); chk("R10 rvalid drops", 32'(busRvalid), 32'd0);
    busRead(22'h001000, d); chk("R1 reset pending", d, 32'd0);
    busRead(22'h200000, d); chk("R9 reset threshold", d, 32'd0);

    // Priority layout and masking, ID 0 hard-wired
    for (int id = 0; id < 32; id++) busWrite(22'(4 * id), 32'hDEADBEE0 + 32'(id * 3));
    for (int id = 0; id < 32; id++) begin
      busRead(22'(4 * id), d);
      chk(id == 0 ? "R8 prio id0" : "R9 prio word", d,
          id == 0 ? 32'd0 : ((32'hDEADBEE0 + 32'(id * 3)) & 32'h7));
    end
    busWrite(22'h002000, 32'hFFFFFFFF);
    busRead(22'h002000, d); chk("R8 enable bit0", d, 32'hFFFFFFFE);
    busWrite(22'h200000, 32'hFFFFFFFD);
    busRead(22'h200000, d); chk("R9 threshold mask", d, 32'd5);
    busWrite(22'h001000, 32'hFFFFFFFF);
    busRead(22'h001000, d); chk("R1 pending read-only", d, 32'd0);

    // Sweep priority patterns x thresholds
    for (int k = 0; k < 3; k++) begin
      for (int t = 0; t < 8; t++) begin
        logic [31:0] enW;
        int it = k * 8 + t;
        for (int i = 1; i < 32; i++) begin
          mPrio[i] = (i * (k + 3) + k) % 8;
          busWrite(22'(4 * i), 32'(mPrio[i]));
        end
        enW = '0;
        for (int i = 1; i < 32; i++) begin
          mEn[i] = (k == 0) ? 1'b1 : (k == 1) ? 1'(i % 2) : 1'(i % 3 != 0);
          enW[i] = mEn[i];
        end
        busWrite(22'h002000, enW);
        mThr = t;
        busWrite(22'h200000, 32'(t));
        srcVec = (it % 2 == 0) ? '1 : 31'h55555555;
        repeat (2) @(negedge clk);
        modelSettle();
        busRead(22'h001000, d); chk("R1 pending latch", d, pendWord());
        for (int n = 0; n < 33; n++) begin
          e = expBest();
          chk("R7 irq level", 32'(irqOut), 32'(e != 0));
          busRead(22'h200004, d);
          chk(e == 0 ? "R4 empty claim" : "R2 R3 claim id", d, 32'(e));
          if (e == 0) break;
          mPend[e] = 1'b0; mServ[e] = 1'b1;
        end
        busRead(22'h001000, d); chk("R5 R6 pending after claims", d, pendWord());
        for (int i = 1; i < 32; i++)
          if (mServ[i]) begin busWrite(22'h200004, 32'(i)); mServ[i] = 1'b0; end
        repeat (2) @(negedge clk);
        modelSettle();
        busRead(22'h001000, d); chk("R6 re-latch after complete", d, pendWord());
      end
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL R10 watchdog expired actual=hung expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule